// File: doc/BRIEF.md
# PWM High/Low Phase Timer

This block measures a periodic pulse-width-modulated sensor line. It counts ticks of a reference timebase. The timebase is a one-cycle enable strobe, typically 1 MHz, which gives 1 µs resolution. One counter times the high phase. The counter is cleared at the falling edge and then times the low phase. It is cleared again at the next rising edge.

At each rising edge that ends a complete period, the block publishes the high and low durations together as one pair and pulses a valid strobe. The asynchronous sensor line is brought into the clock domain by a two-flop synchroniser before edge detection. The counter is built from byte-wide stages joined by a carry chain. It stops at all ones rather than wrapping, and a saturation flag accompanies any pair in which either phase hit that limit.

Top module: `pwm_phase_timer`

## Requirements
- R1: While and after reset, `pair_valid` is 0 and `high_ticks`, `low_ticks` and `sat_flag` are 0 until the first pair is published.
- R2: Only cycles with `tick`=1 advance the duration count. Resolution is one tick.
- R3: `high_ticks` equals the number of ticks counted strictly between the clock edge that acts on a synchronised rising edge and the edge that acts on the following synchronised falling edge.
- R4: `low_ticks` equals the number of ticks counted strictly between the edge that acts on a falling edge and the edge that acts on the next rising edge.
- R5: `pair_valid` is high for exactly one cycle per published period. `high_ticks` and `low_ticks` change only in that cycle and hold their values otherwise.
- R6: A period is published only after a rising edge, then a falling edge, then a rising edge have all occurred since reset. The partial period present at reset is discarded. A line that is high through reset produces no edge until it falls.
- R7: The count saturates at all ones (2^CNT_W-1). `sat_flag` is 1 with a pair if either word of that pair is all ones, and 0 for pairs where neither phase saturated.
- R8: A change of `sense_in` made between clock edges k-1 and k is acted on at edge k+2. `pair_valid` is therefore visible after edge k+2.
- R9: The carry between byte stages is correct, so phases longer than 255 ticks are measured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Reference timebase enable, one cycle per tick |
| sense_in | input | 1 | Asynchronous PWM sensor line |
| high_ticks | output | CNT_W | High-phase duration of the last published period |
| low_ticks | output | CNT_W | Low-phase duration of the last published period |
| sat_flag | output | 1 | A word of the current pair saturated |
| pair_valid | output | 1 | One-cycle strobe: new pair published |

## Verification
A counter that misses a clear shows up in the very next published pair. The word timed from that clear carries leftover counts from the previous phase. A broken carry between byte stages appears only in phases longer than 255 ticks, so long phases are driven on purpose. A wrong arming state shows as a stray `pair_valid` within the first three edges after reset, or as a missing pair after the first full period. Saturation faults appear only after 65,535 ticks, so one deliberately long phase is included.

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sense_in,
  output logic [CNT_W-1:0] high_ticks,
  output logic [CNT_W-1:0] low_ticks,
  output logic             sat_flag,
  output logic             pair_valid
);
  localparam int STAGES = CNT_W / 8;

  logic [2:0]       sync_q;
  logic             rise, fall, at_max;
  logic [CNT_W-1:0] cnt;
  logic [STAGES-1:0] carry;
  logic             armed, have_high, hi_sat;
  logic [CNT_W-1:0] hi_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], sense_in};
  end

  assign rise   = sync_q[1] & ~sync_q[2];
  assign fall   = ~sync_q[1] & sync_q[2];
  assign at_max = &cnt;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign carry[k] = tick & ~at_max;
    end else begin : g_next
      assign carry[k] = carry[k-1] & (&cnt[8*(k-1) +: 8]);
    end
    always_ff @(posedge clk) begin
      if (!rst_n || rise || fall) cnt[8*k +: 8] <= '0;
      else if (carry[k])          cnt[8*k +: 8] <= cnt[8*k +: 8] + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      have_high  <= 1'b0;
      hi_hold    <= '0;
      hi_sat     <= 1'b0;
      high_ticks <= '0;
      low_ticks  <= '0;
      sat_flag   <= 1'b0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (rise) begin
        armed <= 1'b1;
        if (have_high) begin
          high_ticks <= hi_hold;
          low_ticks  <= cnt;
          sat_flag   <= hi_sat | at_max;
          pair_valid <= 1'b1;
        end
      end
      if (fall && armed) begin
        hi_hold   <= cnt;
        hi_sat    <= at_max;
        have_high <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_phase_timer_checks.sv
module pwm_phase_timer_checks #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sense_in,
  input logic [CNT_W-1:0] high_ticks,
  input logic [CNT_W-1:0] low_ticks,
  input logic             sat_flag,
  input logic             pair_valid
);
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  a_r5_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> ($stable(high_ticks) && $stable(low_ticks) && $stable(sat_flag)));

  a_r7_sat_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |-> ((&high_ticks) || (&low_ticks)));

  a_r8_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> ($past(sense_in, 3) && !$past(sense_in, 4)));

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> !pair_valid);
endmodule

bind pwm_phase_timer pwm_phase_timer_checks #(.CNT_W(CNT_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .sense_in(sense_in), .high_ticks(high_ticks),
  .low_ticks(low_ticks), .sat_flag(sat_flag), .pair_valid(pair_valid));

// File: tb/pwm_phase_timer_bench.sv
module pwm_phase_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, sense_in = 1'b0;
  logic [CNT_W-1:0] high_ticks, low_ticks;
  logic sat_flag, pair_valid;

  int checks = 0, errors = 0, pairs_seen = 0, pairs_exp = 0;
  logic m1, m2, m3, m_armed, m_have;
  logic [CNT_W-1:0] m_cnt, m_hold;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_phase_timer #(.CNT_W(CNT_W)) u_pwm_phase_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sense_in(sense_in),
    .high_ticks(high_ticks), .low_ticks(low_ticks),
    .sat_flag(sat_flag), .pair_valid(pair_valid));

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v, input logic t);
    return (t && v != MAXV) ? v + 1'b1 : v;
  endfunction

  task automatic check(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock with the given inputs; the model follows R3-R8
  task automatic step(input logic s, input logic t);
    logic rise, fall, exp_v;
    logic [CNT_W-1:0] eh, el;
    @(negedge clk);
    sense_in = s; tick = t;
    @(posedge clk);
    rise = m2 & ~m3; fall = ~m2 & m3;
    exp_v = 1'b0; eh = '0; el = '0;
    if (rise && m_have) begin exp_v = 1'b1; eh = m_hold; el = m_cnt; end
    if (rise) m_armed = 1'b1;
    if (fall && m_armed) begin m_hold = m_cnt; m_have = 1'b1; end
    m_cnt = (rise || fall) ? '0 : bump(m_cnt, t);
    m3 = m2; m2 = m1; m1 = s;
    #1;
    if (exp_v) begin
      pairs_exp++;
      check("R5/R8 valid strobe", {{(CNT_W-1){1'b0}}, pair_valid}, 1);
      check("R3/R9 high word", high_ticks, eh);
      check("R4/R9 low word", low_ticks, el);
      check("R7 sat flag", {{(CNT_W-1){1'b0}}, sat_flag},
            {{(CNT_W-1){1'b0}}, (eh == MAXV) || (el == MAXV)});
    end else if (pair_valid) begin
      checks++; errors++;
      $display("FAIL R6 stray valid: actual=1 expected=0");
    end
    if (pair_valid) pairs_seen++;
  endtask

  task automatic phase(input logic s, input int len, input int tick_mode);
    for (int i = 0; i < len; i++)
      step(s, tick_mode == 2 ? 1'b1 : (tick_mode == 0 ? 1'b0 : ($urandom % 4 != 0)));
  endtask

  initial begin
    void'($urandom(32'd12345));
    m1 = 1'b1; m2 = 1'b1; m3 = 1'b1;
    m_armed = 1'b0; m_have = 1'b0; m_cnt = '0; m_hold = '0;
    sense_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset high word", high_ticks, '0);
    check("R1 reset low word", low_ticks, '0);
    check("R1 reset valid", {{(CNT_W-1){1'b0}}, pair_valid}, '0);
    @(negedge clk); rst_n = 1'b1;
    // R6: high through reset, partial low, then full periods
    phase(1, 7, 2);
    phase(0, 9, 2);
    check("R6 no pair before full period", pairs_seen, 0);
    phase(1, 12, 2);
    phase(0, 5, 2);
    phase(1, 4, 0);
    check("R6 first pair after full period", pairs_seen, 1);
    // R2: tick gating, no ticks in low phase
    phase(0, 20, 0);
    phase(1, 10, 1);
    phase(0, 3, 2);
    // R9: phases crossing byte boundary
    phase(1, 700, 2);
    phase(0, 300, 1);
    phase(1, 5, 1);
    // random periods, R3/R4
    for (int n = 0; n < 40; n++) begin
      phase(1, 3 + $urandom % 400, 1);
      phase(0, 3 + $urandom % 400, 1);
    end
    // R7: saturating high phase then a normal period
    phase(0, 10, 1);
    phase(1, 66000, 2);
    phase(0, 50, 2);
    phase(1, 40, 2);
    phase(0, 30, 1);
    phase(1, 5, 0);
    check("R5 pair count", pairs_seen, pairs_exp);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule